// File: doc/BRIEF.md
# Late-Write Register-Latch Synchronous SRAM

This block is a single-port synchronous memory with late writes and register-latch reads. Every command is taken on the rising clock edge: deselect, read or write, with its address and byte write enables. A read places its word on the output half a cycle later, at the next falling edge. A write takes its address in one cycle and its data on the rising edge of the cycle after. The data is parked in a one-deep write buffer, together with the address and the bytes that the write enabled. It reaches the register array only when the data of a later write arrives.

Reads check the parked entry. When the read address matches it, the enabled bytes come from the buffer and the other bytes come from the array, so a read always sees the most recent write. The data bus is split into an input word, an output word and an output-enable flag. A low output enable stands for a high-impedance bus. An asynchronous sleep input drops the output enable at once, blocks new commands and keeps the stored data.

Top module: `latewrite_sram`

## Requirements
- R1: With `sel_n` high at a rising edge (deselect), no array word and no pending entry changes, and `dq_oe` is low after the following falling edge.
- R2: With `sel_n` low and `we_n` high at a rising edge (read), `dq_oe` rises and `dq_o` carries the addressed word after the following falling edge. Both hold until the next falling edge.
- R3: With `sel_n` and `we_n` both low at a rising edge (write), the word on `dq_i` at the next rising edge is the data for that address. Later reads of that address return it.
- R4: `bwe_n` bit i is active low and controls byte i, which is `dq_i[8i+7:8i]` with the default byte width. Only the enabled bytes of the addressed word change.
- R5: A write with every `bwe_n` bit high is aborted. It changes no byte, ignores the following data cycle and leaves the earlier pending entry in place.
- R6: A read whose address equals the pending entry returns the buffered enabled bytes merged over the array word. This includes a read issued in the same cycle as that entry's data.
- R7: The pending entry is written to the array at the rising edge that captures the data of the next accepted write, before the new entry replaces it. Reads and deselects leave it untouched, so back-to-back writes all reach the array.
- R8: `dq_oe` is low in the half cycle after any non-read command, including write address cycles and aborted writes.
- R9: While `sleep` is high, `dq_oe` is low with no clock edge needed, commands sampled at rising edges are treated as deselects, and the stored data is kept.
- R10: `rst` high at a rising edge clears the pending-entry valid flag, the write-data wait state and the output enable. A pending entry lost to reset never reaches the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Commands are taken on the rising edge and output data on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Asynchronous power-down. Forces the output enable low and blocks commands |
| sel_n | input | 1 | Active-low select. High means deselect |
| we_n | input | 1 | Active-low write enable. High with select low means read |
| bwe_n | input | NBYTES | Active-low byte write enables, bit i for byte i |
| addr | input | ADDR_W | Word address |
| dq_i | input | NBYTES*BYTE_W | Input half of the data bus. Write data, one cycle after its address |
| dq_o | output | NBYTES*BYTE_W | Output half of the data bus. Read data |
| dq_oe | output | 1 | Output drive enable. Low means the bus is high-impedance |

## Verification
The bench reads an address in the same cycle its late data arrives. A design that looked up the buffer before loading it would return the stale array word there. It also issues a partial write followed by a forwarded read, to catch a design that forwards whole words instead of merging bytes. Back-to-back writes show whether the parked entry is committed before it is overwritten; a design that gets this wrong silently loses the first write. Further directed cases cover an aborted write that must not evict or alter the pending entry, sleep raised mid-cycle, which must drop the output enable without an edge, and reset with a write still parked, which must leave the older array value readable.

// File: rtl/lw_pkg.sv
package lw_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;

  // Command decode for one rising edge; sleep turns anything into a no-op.
  function automatic op_e decode_op(input logic sleep, input logic sel_n, input logic we_n);
    if (sleep || sel_n) return OP_NOP;
    if (we_n)           return OP_RD;
    return OP_WR;
  endfunction

endpackage

// File: rtl/lw_ctrl.sv
module lw_ctrl
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              sel_n,
  input  logic              we_n,
  input  logic [NBYTES-1:0] bwe_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_now,
  output logic              accept_rd,
  output logic              accept_wr,
  output logic              rd_q,
  output logic [ADDR_W-1:0] rd_addr_q,
  output logic              wr_pend,
  output logic [ADDR_W-1:0] wr_addr_q,
  output logic [NBYTES-1:0] wr_be_q
);

  logic              abort_wr;
  logic [NBYTES-1:0] be_hi;

  assign op_now    = decode_op(sleep, sel_n, we_n);
  assign be_hi     = ~bwe_n;
  assign accept_rd = (op_now == OP_RD);
  assign accept_wr = (op_now == OP_WR) && (|be_hi);
  assign abort_wr  = (op_now == OP_WR) && !(|be_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 1'b0;
      wr_pend <= 1'b0;
    end else begin
      rd_q    <= accept_rd;
      wr_pend <= accept_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (accept_rd) rd_addr_q <= addr;
    if (accept_wr) begin
      wr_addr_q <= addr;
      wr_be_q   <= be_hi;
    end
  end

  // R5: an aborted write never opens a data phase
  p_abort_drops_r5: assert property (@(posedge clk) disable iff (rst)
    abort_wr |=> !wr_pend);

endmodule

// File: rtl/lw_wbuf.sv
module lw_wbuf #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8,
  localparam int DW = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [NBYTES-1:0] ld_be,
  input  logic [DW-1:0]     ld_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DW-1:0]     arr_rdata,
  output logic              commit_en,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [NBYTES-1:0] cm_be,
  output logic [DW-1:0]     cm_data,
  output logic              buf_valid,
  output logic [DW-1:0]     fwd_data
);

  logic [ADDR_W-1:0] buf_addr;
  logic [NBYTES-1:0] buf_be;
  logic [DW-1:0]     buf_data;
  logic              hit;

  // Byte-wise overlay: enabled bytes of top replace those of base.
  function automatic logic [DW-1:0] overlay(input logic [DW-1:0] base,
                                            input logic [DW-1:0] top,
                                            input logic [NBYTES-1:0] be);
    logic [DW-1:0] res;
    res = base;
    for (int b = 0; b < NBYTES; b++)
      if (be[b]) res[b*BYTE_W +: BYTE_W] = top[b*BYTE_W +: BYTE_W];
    return res;
  endfunction

  // Old entry drains on the same edge that the new one arrives.
  assign commit_en = load_en && buf_valid;
  assign cm_addr   = buf_addr;
  assign cm_be     = buf_be;
  assign cm_data   = buf_data;

  always_ff @(posedge clk) begin
    if (rst) buf_valid <= 1'b0;
    else if (load_en) buf_valid <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      buf_addr <= ld_addr;
      buf_be   <= ld_be;
      buf_data <= ld_data;
    end
  end

  assign hit      = buf_valid && (buf_addr == rd_addr);
  assign fwd_data = hit ? overlay(arr_rdata, buf_data, buf_be) : arr_rdata;

  // R7: with no new data the pending entry stays as it was
  p_pending_kept_r7: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> ($stable(buf_valid) && $stable(buf_addr) && $stable(buf_data) && $stable(buf_be)));

endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8,
  localparam int DW    = NBYTES * BYTE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [NBYTES-1:0] wbe,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < NBYTES; b++)
        if (wbe[b]) mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/lw_outlatch.sv
module lw_outlatch #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep,
  input  logic          rd_q,
  input  logic [DW-1:0] rdata,
  output logic          oe_state,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe
);

  // Falling-edge stage: half a cycle after the read was captured.
  always_ff @(negedge clk) begin
    if (rst) oe_state <= 1'b0;
    else     oe_state <= rd_q;
  end

  always_ff @(negedge clk) begin
    if (rd_q) dq_o <= rdata;
  end

  assign dq_oe = oe_state && !sleep;

endmodule

// File: rtl/latewrite_sram.sv
module latewrite_sram
  import lw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8,
  localparam int DW = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              sel_n,
  input  logic              we_n,
  input  logic [NBYTES-1:0] bwe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     dq_i,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe
);

  op_e               op_now;
  logic              accept_rd, accept_wr;
  logic              rd_q, wr_pend;
  logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;
  logic [NBYTES-1:0] wr_be_q;
  logic              commit_en, buf_valid, oe_state;
  logic [ADDR_W-1:0] cm_addr;
  logic [NBYTES-1:0] cm_be;
  logic [DW-1:0]     cm_data, arr_rdata, fwd_data;

  lw_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
    .clk(clk), .rst(rst), .sleep(sleep), .sel_n(sel_n), .we_n(we_n),
    .bwe_n(bwe_n), .addr(addr), .op_now(op_now),
    .accept_rd(accept_rd), .accept_wr(accept_wr),
    .rd_q(rd_q), .rd_addr_q(rd_addr_q),
    .wr_pend(wr_pend), .wr_addr_q(wr_addr_q), .wr_be_q(wr_be_q)
  );

  lw_wbuf #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_wbuf (
    .clk(clk), .rst(rst), .load_en(wr_pend), .ld_addr(wr_addr_q),
    .ld_be(wr_be_q), .ld_data(dq_i), .rd_addr(rd_addr_q),
    .arr_rdata(arr_rdata), .commit_en(commit_en), .cm_addr(cm_addr),
    .cm_be(cm_be), .cm_data(cm_data), .buf_valid(buf_valid),
    .fwd_data(fwd_data)
  );

  lw_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .we(commit_en), .waddr(cm_addr), .wbe(cm_be),
    .wdata(cm_data), .raddr(rd_addr_q), .rdata(arr_rdata)
  );

  lw_outlatch #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .sleep(sleep), .rd_q(rd_q), .rdata(fwd_data),
    .oe_state(oe_state), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  // R2: an accepted read enables the driver by the next rising edge
  p_read_drives_r2: assert property (@(posedge clk) disable iff (rst)
    accept_rd |=> oe_state);

  // R8 (and R1): any non-read command leaves the driver off
  p_nonread_hiz_r8: assert property (@(posedge clk) disable iff (rst)
    (op_now != OP_RD) |=> !oe_state);

  // R10: reset drops the pending entry and the data wait state
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (!buf_valid && !wr_pend));

  // R3: a write data phase follows only an accepted write address
  p_data_follows_addr_r3: assert property (@(posedge clk) disable iff (rst)
    !accept_wr |=> !wr_pend);

endmodule

// File: tb/latewrite_sram_test.sv
`timescale 1ns/1ps
module latewrite_sram_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleep = 1'b0;
  logic        sel_n = 1'b1;
  logic        we_n = 1'b1;
  logic [3:0]  bwe_n = 4'hF;
  logic [5:0]  addr = '0;
  logic [31:0] dq_i = '0;
  logic [31:0] dq_o;
  logic        dq_oe;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  latewrite_sram uut (
    .clk(clk), .rst(rst), .sleep(sleep), .sel_n(sel_n), .we_n(we_n),
    .bwe_n(bwe_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  // Entry: sel_n, we_n, bwe_n[3:0], addr[5:0], din[31:0], exp_oe, exp_q[31:0]
  localparam int NV = 18;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0,1'b0,4'b0000,6'd1,32'h0,       1'b0,32'h0},        // 0 W a1 (R3)
    {1'b0,1'b0,4'b0000,6'd2,32'h11111111,1'b0,32'h0},        // 1 W a2, data a1 (R8)
    {1'b0,1'b1,4'b1111,6'd1,32'h22222222,1'b1,32'h11111111}, // 2 R a1, data a2 (R3)
    {1'b0,1'b1,4'b1111,6'd2,32'h0,       1'b1,32'h22222222}, // 3 R a2 forwarded (R6)
    {1'b0,1'b0,4'b1010,6'd2,32'h0,       1'b0,32'h0},        // 4 W a2 bytes 0,2 (R4)
    {1'b0,1'b1,4'b1111,6'd2,32'hAABBCCDD,1'b1,32'h22BB22DD}, // 5 R a2 same cycle as data (R6)
    {1'b0,1'b0,4'b1111,6'd3,32'h0,       1'b0,32'h0},        // 6 aborted W (R5)
    {1'b0,1'b1,4'b1111,6'd2,32'h55555555,1'b1,32'h22BB22DD}, // 7 abort data ignored (R5)
    {1'b1,1'b1,4'b1111,6'd2,32'h0,       1'b0,32'h0},        // 8 deselect (R1)
    {1'b0,1'b1,4'b1111,6'd1,32'h0,       1'b1,32'h11111111}, // 9 R a1 (R2)
    {1'b0,1'b0,4'b0000,6'd4,32'h0,       1'b0,32'h0},        // 10 W a4
    {1'b0,1'b0,4'b0000,6'd5,32'h44444444,1'b0,32'h0},        // 11 W a5 back-to-back (R7)
    {1'b0,1'b1,4'b1111,6'd4,32'h50505050,1'b1,32'h44444444}, // 12 R a4 from array (R7)
    {1'b0,1'b1,4'b1111,6'd5,32'h0,       1'b1,32'h50505050}, // 13 R a5 forwarded (R6)
    {1'b0,1'b1,4'b1111,6'd2,32'h0,       1'b1,32'h22BB22DD}, // 14 R a2 committed merge (R7)
    {1'b0,1'b0,4'b0111,6'd4,32'h0,       1'b0,32'h0},        // 15 W a4 byte3 only (R4)
    {1'b1,1'b1,4'b1111,6'd0,32'h9ABCDEF0,1'b0,32'h0},        // 16 deselect carries data (R1)
    {1'b0,1'b1,4'b1111,6'd4,32'h0,       1'b1,32'h9A444444}  // 17 partial forward (R4)
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present inputs, pass the capture edge and the following falling edge,
  // then settle 1 ns so outputs of this command are visible.
  task automatic step(input logic s, input logic w, input logic [3:0] b,
                      input logic [5:0] a, input logic [31:0] d);
    sel_n = s; we_n = w; bwe_n = b; addr = a; dq_i = d;
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #200000;
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1'b1;
    step(1, 1, 4'hF, 0, 0);
    step(1, 1, 4'hF, 0, 0);
    check("R10 reset oe", {31'b0, dq_oe}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][76], VEC[i][75], VEC[i][74:71], VEC[i][70:65], VEC[i][64:33]);
      check($sformatf("R8/R2 vec%0d oe", i), {31'b0, dq_oe}, {31'b0, VEC[i][32]});
      if (VEC[i][32]) check($sformatf("R6/R3 vec%0d data", i), dq_o, VEC[i][31:0]);
    end

    // R2: read data holds until the next falling edge
    step(0, 1, 4'hF, 6'd1, 0);
    sel_n = 1'b1; we_n = 1'b1;
    @(posedge clk); #1;
    check("R2 hold oe", {31'b0, dq_oe}, 32'd1);
    check("R2 hold data", dq_o, 32'h11111111);
    @(negedge clk); #1;
    check("R1 deselect oe", {31'b0, dq_oe}, 32'd0);

    // R9: sleep drops the driver asynchronously and blocks commands
    step(0, 1, 4'hF, 6'd1, 0);
    sleep = 1'b1;
    #0.2;
    check("R9 async hi-z", {31'b0, dq_oe}, 32'd0);
    step(0, 0, 4'h0, 6'd1, 0);
    step(1, 1, 4'hF, 6'd0, 32'hDEADBEEF);
    step(0, 1, 4'hF, 6'd1, 0);
    check("R9 read blocked", {31'b0, dq_oe}, 32'd0);
    sleep = 1'b0;
    step(0, 1, 4'hF, 6'd1, 0);
    check("R9 array kept", dq_o, 32'h11111111);
    step(0, 1, 4'hF, 6'd4, 0);
    check("R9 pending kept", dq_o, 32'h9A444444);

    // R10: reset with an entry pending keeps the older array value
    step(0, 0, 4'h0, 6'd6, 0);
    step(0, 0, 4'h0, 6'd7, 32'h600D0001);
    step(0, 0, 4'h0, 6'd6, 32'h77770007);
    step(1, 1, 4'hF, 6'd0, 32'hBADBAD02);
    rst = 1'b1;
    step(1, 1, 4'hF, 6'd0, 0);
    check("R10 reset oe", {31'b0, dq_oe}, 32'd0);
    rst = 1'b0;
    step(0, 1, 4'hF, 6'd6, 0);
    check("R10 pending dropped", dq_o, 32'h600D0001);
    step(0, 1, 4'hF, 6'd7, 0);
    check("R7 back-to-back commit", dq_o, 32'h77770007);
    step(0, 1, 4'hF, 6'd4, 0);
    check("R7 partial committed", dq_o, 32'h9A444444);

    summary();
  end

endmodule